// File: doc/BRIEF.md
# Guarded Halfword Store Unit

This unit carries out a single 16-bit store. The caller supplies a base address, a 7-bit displacement field, a source word, a guard word and a flag that says whether the guard is present. The unit forms the effective address and checks it. It then turns the low halfword of the source into one write beat on a 32-bit byte-enabled memory port. A runtime endianness bit decides which of the two bytes lands at the lower address.

The unit also keeps the status side of the store. An odd effective address suppresses the write and sets a sticky misaligned-store flag. An address inside the memory-mapped I/O window also suppresses the write, and it sets a separate sticky error flag. If trapping is enabled when a misaligned store is accepted, a trap is armed. The trap is reported only when the next interruptible-jump strobe arrives, and that strobe disarms it. A guard whose least significant bit is 0 cancels the whole operation.

Requests enter through a valid/ready handshake, and write beats leave through another. The output holds one registered beat. The request side is ready whenever that register is empty or is being drained in the same cycle. While the memory side holds ready low, a pending beat stays unchanged and no new request is taken.

Top module: `hstore_unit`

## Requirements
- R1: The effective address EA is `req_base + 2 * signext(req_disp)`, where `req_disp` is a 7-bit two's-complement field. Every issued beat drives `wr_addr` = EA with bits 1:0 cleared. It drives `wr_be` = 4'b0011 when EA[1] = 0 and 4'b1100 when EA[1] = 1.
- R2: Only `req_data[15:0]` is stored, and bits 31:16 have no effect. Byte lane k is `wr_data[8k+7:8k]` and maps to byte address `wr_addr + k`. With `be_mode` = 0 (little-endian), `req_data[7:0]` goes to EA and `req_data[15:8]` goes to EA+1. With `be_mode` = 1 (big-endian), the two bytes swap places. Both 16-bit halves of `wr_data` carry the same byte pair.
- R3: When `req_has_guard` = 1 and `req_guard[0]` = 0, an accepted request issues no beat, sets no flag and arms no trap. Bits 31:1 of `req_guard` are ignored. When `req_has_guard` = 0, the store proceeds.
- R4: A proceeding store with an odd EA issues no beat. `misalign_flag` reads 1 from the cycle after acceptance.
- R5: `misalign_flag` stays set until a cycle with `clr_misalign` = 1. If a set and a clear happen in the same cycle, the set wins.
- R6: A misaligned store accepted while `trap_en` = 1 arms a trap. `trap_req` is high in a cycle where `ijump` = 1 and a trap is armed, and that jump disarms the trap. `trap_req` is low whenever `ijump` = 0, and a misaligned store accepted with `trap_en` = 0 arms nothing.
- R7: A proceeding store whose EA[31:21] matches the window base (default 0xEFE00000, 2 MiB) issues no beat and sets `mmio_err_flag`. That flag stays set until `clr_mmio`.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1, where `req_ready` = !`wr_valid` || `wr_ready`. While `wr_valid` = 1 and `wr_ready` = 0, the beat on `wr_addr`/`wr_be`/`wr_data` holds stable.
- R9: After reset, `wr_valid`, both flags and the armed trap are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_has_guard | input | 1 | Request carries a guard operand |
| req_guard | input | 32 | Guard operand, only bit 0 used |
| req_base | input | 32 | Base address operand |
| req_data | input | 32 | Source operand, low halfword stored |
| req_disp | input | 7 | Signed displacement field, scaled by 2 |
| be_mode | input | 1 | Byte order: 0 little-endian, 1 big-endian |
| trap_en | input | 1 | Arm a trap on misaligned store |
| ijump | input | 1 | Interruptible-jump strobe |
| clr_misalign | input | 1 | Clear the misaligned-store flag |
| clr_mmio | input | 1 | Clear the I/O-window error flag |
| misalign_flag | output | 1 | Sticky misaligned-store flag |
| mmio_err_flag | output | 1 | Sticky I/O-window error flag |
| trap_req | output | 1 | Exception request at an interruptible jump |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory takes the beat this cycle |
| wr_addr | output | 32 | Word-aligned write address |
| wr_be | output | 4 | Byte enables, bit k for lane k |
| wr_data | output | 32 | Write data with bytes on their lanes |

## Verification
The assertions assume that the memory side never withdraws a beat on its own, so back-pressure comes only from `wr_ready`. They also assume that the strobe and clear inputs are single-cycle levels sampled at the clock edge. The stimulus changes inputs only at the falling edge. It holds `trap_en` low during the sweep, so the trap is armed only in the dedicated sequence. It keeps the swept base addresses far from the I/O window, so window hits come only from the targeted vector.

// File: rtl/hst_pkg.sv
package hst_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } byte_order_e;
endpackage

// File: rtl/hst_agen.sv
module hst_agen #(
  parameter int              ADDR_W    = 32,
  parameter int              DISP_W    = 7,
  parameter int              WIN_AW    = 21,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hEFE0_0000
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea,
  output logic              odd_addr,
  output logic              win_hit
);
  localparam int EXT_W = ADDR_W - DISP_W - 1;

  logic [ADDR_W-1:0] offset;

  // displacement field counts halfwords: sign-extend then scale by 2
  assign offset   = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
  assign ea       = base + offset;
  assign odd_addr = ea[0];
  assign win_hit  = (ea[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
endmodule

// File: rtl/hst_lane.sv
module hst_lane
  import hst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [15:0]       half,
  input  byte_order_e       order,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W/BYTE_W-1:0] be,
  output logic [DATA_W-1:0] wdata
);
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_B = $clog2(LANES);

  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;
  logic              unused_ea_lsb;

  assign unused_ea_lsb = ea[0];
  assign word_addr     = {ea[ADDR_W-1:LANE_B], {LANE_B{1'b0}}};

  // byte at the lower (even) address, and the one after it
  assign first_b  = (order == ORDER_BIG) ? half[15:8] : half[7:0];
  assign second_b = (order == ORDER_BIG) ? half[7:0]  : half[15:8];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [LANE_B-1:0] PAIR = LANE_B'(k / 2);
    assign be[k] = (ea[LANE_B-1:1] == PAIR[LANE_B-2:0]);
    if (k % 2 == 0) begin : g_even
      assign wdata[k*BYTE_W +: BYTE_W] = first_b;
    end else begin : g_odd
      assign wdata[k*BYTE_W +: BYTE_W] = second_b;
    end
  end
endmodule

// File: rtl/hst_status.sv
module hst_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_mis,
  input  logic set_win,
  input  logic clr_mis,
  input  logic clr_win,
  input  logic trap_en,
  input  logic ijump,
  output logic mis_flag,
  output logic win_flag,
  output logic trap_req
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mis_flag <= 1'b0;
      win_flag <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      mis_flag <= set_mis | (mis_flag & ~clr_mis);
      win_flag <= set_win | (win_flag & ~clr_win);
      if (set_mis && trap_en) armed_q <= 1'b1;
      else if (ijump)         armed_q <= 1'b0;
    end
  end

  assign trap_req = ijump & armed_q;

  AST_MIS_SETS:   assert property (@(posedge clk) disable iff (!rst_n)
                    set_mis |=> mis_flag);                              // R4
  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                    (mis_flag && !clr_mis) |=> mis_flag);               // R5
  AST_WIN_SETS:   assert property (@(posedge clk) disable iff (!rst_n)
                    set_win |=> win_flag);                              // R7
  AST_TRAP_ONCE:  assert property (@(posedge clk) disable iff (!rst_n)
                    (trap_req && !(set_mis && trap_en)) |=> !trap_req); // R6
endmodule

// File: rtl/hstore_unit.sv
module hstore_unit
  import hst_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter int               DISP_W   = 7,
  parameter int               WIN_AW   = 21,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hEFE0_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_has_guard,
  input  logic [DATA_W-1:0]         req_guard,
  input  logic [ADDR_W-1:0]         req_base,
  input  logic [DATA_W-1:0]         req_data,
  input  logic [DISP_W-1:0]         req_disp,
  input  logic                      be_mode,
  input  logic                      trap_en,
  input  logic                      ijump,
  input  logic                      clr_misalign,
  input  logic                      clr_mmio,
  output logic                      misalign_flag,
  output logic                      mmio_err_flag,
  output logic                      trap_req,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W/BYTE_W-1:0]  wr_be,
  output logic [DATA_W-1:0]         wr_data
);
  localparam int LANES = DATA_W / BYTE_W;

  logic [ADDR_W-1:0] ea;
  logic              odd_addr;
  logic              win_hit;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_be;
  logic [DATA_W-1:0] beat_data;
  logic              accept;
  logic              proceed;
  logic              issue;
  logic              unused_bits;

  assign unused_bits = ^{req_guard[DATA_W-1:1], req_data[DATA_W-1:16]};

  assign req_ready = !wr_valid || wr_ready;
  assign accept    = req_valid && req_ready;
  assign proceed   = !req_has_guard || req_guard[0];
  assign issue     = accept && proceed && !odd_addr && !win_hit;

  hst_agen #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE)
  ) u_agen (
    .base(req_base), .disp(req_disp), .ea(ea),
    .odd_addr(odd_addr), .win_hit(win_hit)
  );

  hst_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .ea(ea), .half(req_data[15:0]), .order(byte_order_e'(be_mode)),
    .word_addr(beat_addr), .be(beat_be), .wdata(beat_data)
  );

  hst_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_mis(accept && proceed && odd_addr),
    .set_win(accept && proceed && win_hit),
    .clr_mis(clr_misalign), .clr_win(clr_mmio),
    .trap_en(trap_en), .ijump(ijump),
    .mis_flag(misalign_flag), .win_flag(mmio_err_flag), .trap_req(trap_req)
  );

  // one-deep output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_be    <= '0;
      wr_data  <= '0;
    end else if (issue) begin
      wr_valid <= 1'b1;
      wr_addr  <= beat_addr;
      wr_be    <= beat_be;
      wr_data  <= beat_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  AST_GUARD_OFF_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
                           (accept && !proceed) |=> !wr_valid);          // R3
  AST_ODD_NO_BEAT:       assert property (@(posedge clk) disable iff (!rst_n)
                           (accept && odd_addr) |=> !wr_valid);          // R4
  AST_BEAT_HELD:         assert property (@(posedge clk) disable iff (!rst_n)
                           (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)
                           && $stable(wr_be) && $stable(wr_data)));      // R8
  AST_BE_PAIR:           assert property (@(posedge clk) disable iff (!rst_n)
                           wr_valid |-> ($countones(wr_be) == 2));       // R1
endmodule

// File: tb/hstore_unit_tb.sv
module hstore_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_has_guard;
  logic [31:0] req_guard, req_base, req_data;
  logic [6:0]  req_disp;
  logic        be_mode, trap_en, ijump, clr_misalign, clr_mmio;
  logic        misalign_flag, mmio_err_flag, trap_req;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic mflag_m = 0;
  logic eflag_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hstore_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_has_guard(req_has_guard), .req_guard(req_guard), .req_base(req_base),
    .req_data(req_data), .req_disp(req_disp), .be_mode(be_mode),
    .trap_en(trap_en), .ijump(ijump), .clr_misalign(clr_misalign),
    .clr_mmio(clr_mmio), .misalign_flag(misalign_flag),
    .mmio_err_flag(mmio_err_flag), .trap_req(trap_req), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, let it be taken, check results
  task automatic apply(input logic [31:0] base, input logic [6:0] disp,
                       input logic [31:0] data, input logic hg,
                       input logic [31:0] g, input logic order);
    logic [31:0] ea;
    logic        go, mis, win, expv;
    logic [7:0]  b0, b1;
    ea  = base + {{24{disp[6]}}, disp, 1'b0};
    go  = !hg || g[0];
    mis = ea[0];
    win = (ea[31:21] == 11'h77F);
    expv = go && !mis && !win;
    b0  = order ? data[15:8] : data[7:0];
    b1  = order ? data[7:0]  : data[15:8];
    req_base = base; req_disp = disp; req_data = data;
    req_has_guard = hg; req_guard = g; be_mode = order; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mflag_m = mflag_m | (go && mis);
    eflag_m = eflag_m | (go && win);
    chk(hg && !g[0] ? "R3 beat" : (mis ? "R4 beat" : (win ? "R7 beat" : "R1 beat")),
        {31'b0, wr_valid}, {31'b0, expv});
    if (expv) begin
      chk("R1 addr", wr_addr, {ea[31:2], 2'b00});
      chk("R1 be", {28'b0, wr_be}, ea[1] ? 32'hC : 32'h3);
      chk("R2 data", wr_data, {b1, b0, b1, b0});
    end
    chk("R4 R5 R3 flag", {31'b0, misalign_flag}, {31'b0, mflag_m});
    chk("R7 flag", {31'b0, mmio_err_flag}, {31'b0, eflag_m});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [5];
    bases = '{32'h0000_0CFE, 32'h0000_0CFF, 32'h0000_1000, 32'h0000_1001, 32'h8000_0002};
    rst_n = 0; req_valid = 0; req_has_guard = 0; req_guard = 0; req_base = 0;
    req_data = 0; req_disp = 0; be_mode = 0; trap_en = 0; ijump = 0;
    clr_misalign = 0; clr_mmio = 0; wr_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 wr_valid", {31'b0, wr_valid}, 32'h0);
    chk("R9 misalign", {31'b0, misalign_flag}, 32'h0);
    chk("R9 mmio", {31'b0, mmio_err_flag}, 32'h0);
    ijump = 1; #1;
    chk("R9 trap", {31'b0, trap_req}, 32'h0);
    ijump = 0;
    rst_n = 1;
    @(negedge clk);

    // R2 worked examples: big-endian, then little-endian with a true guard
    apply(32'h0000_0CFE, 7'h01, 32'h4433_2211, 1'b0, 32'h0, 1'b1);
    chk("R2 big lane0", {24'b0, wr_data[7:0]}, 32'h22);
    chk("R2 big lane1", {24'b0, wr_data[15:8]}, 32'h11);
    apply(32'h0000_0D06, 7'h7E, 32'hAABB_CCDD, 1'b1, 32'h1, 1'b0);
    chk("R2 little addr", wr_addr, 32'h0000_0D00);
    chk("R2 little lane2", {24'b0, wr_data[23:16]}, 32'hDD);
    chk("R2 little lane3", {24'b0, wr_data[31:24]}, 32'hCC);

    // sweep: order x displacement x base x guard case
    for (int o = 0; o < 2; o++)
      for (int d = 0; d < 128; d++)
        for (int b = 0; b < 5; b++)
          for (int gc = 0; gc < 3; gc++)
            apply(bases[b], 7'(d), 32'h5A00_0000 ^ (d * 32'h0001_0307) ^ (b << 20),
                  gc != 0, gc == 1 ? 32'hFFFF_FFFE : 32'h0000_0001, o[0]);

    // R5 clear, then set-wins-over-clear
    clr_misalign = 1; @(posedge clk); @(negedge clk); clr_misalign = 0; mflag_m = 0;
    chk("R5 cleared", {31'b0, misalign_flag}, 32'h0);
    clr_misalign = 1;
    apply(32'h0000_0101, 7'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    clr_misalign = 0;
    chk("R5 set wins", {31'b0, misalign_flag}, 32'h1);
    clr_misalign = 1; @(posedge clk); @(negedge clk); clr_misalign = 0; mflag_m = 0;

    // R6 trap deferred to the jump and consumed by it
    trap_en = 1;
    apply(32'h0000_0201, 7'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    trap_en = 0;
    chk("R6 no jump", {31'b0, trap_req}, 32'h0);
    ijump = 1; #1;
    chk("R6 at jump", {31'b0, trap_req}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk("R6 consumed", {31'b0, trap_req}, 32'h0);
    ijump = 0;
    apply(32'h0000_0203, 7'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    ijump = 1; #1;
    chk("R6 disabled", {31'b0, trap_req}, 32'h0);
    @(posedge clk); @(negedge clk); ijump = 0;

    // R7 I/O window hit, then clear
    apply(32'hEFE0_0010, 7'h0, 32'h1234, 1'b0, 32'h0, 1'b0);
    clr_mmio = 1; @(posedge clk); @(negedge clk); clr_mmio = 0; eflag_m = 0;
    chk("R7 cleared", {31'b0, mmio_err_flag}, 32'h0);

    // R8 back-pressure
    wr_ready = 0;
    req_base = 32'h0000_4000; req_disp = 7'h0; req_data = 32'h0000_BEEF;
    req_has_guard = 0; be_mode = 0; req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_base = 32'h0000_5002;
    chk("R8 held valid", {31'b0, wr_valid}, 32'h1);
    chk("R8 not ready", {31'b0, req_ready}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 addr stable", wr_addr, 32'h0000_4000);
      chk("R8 data stable", wr_data, 32'hBEEF_BEEF);
    end
    wr_ready = 1; #1;
    chk("R8 ready on drain", {31'b0, req_ready}, 32'h1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R8 next beat", wr_addr, 32'h0000_5000);
    chk("R8 next be", {28'b0, wr_be}, 32'hC);
    @(posedge clk); @(negedge clk);
    chk("R8 drained", {31'b0, wr_valid}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule